// File: doc/BRIEF.md
# Burst Flash Configuration Command Decoder

This block sits on the write side of a synchronous burst flash device model. It watches bus write cycles for a four-write unlock-and-load command. The first three writes are fixed address/data pairs. The fourth write carries a 16-bit configuration word, which the block stores in its configuration register. The block then decodes the stored word into the mode fields that the read side needs: asynchronous or synchronous burst reads, initial access latency in clock cycles, burst ordering, output clock edge, and burst length.

The write port is a plain strobe interface with no back-pressure. Every cycle with `wr_en` high is one bus write, and the block always takes it. A write that does not fit the expected next step abandons the command. The load is refused while the device reports that an embedded program or erase operation is running. Reset restores a default word, so that boot reads run asynchronously with the longest latency.

Top module: `bfcfg_top`

## Requirements
- R1: After reset `cfg_word` is 16'h9CC7. This gives asynchronous reads, a 9-cycle initial latency (code 0111), linear bursts, the rising clock edge and continuous burst length.
- R2: The command is four writes in order. Write 1 has address 'h555 and `wr_data[7:0]`='hAA. Write 2 has address 'h2AA and `wr_data[7:0]`='h55. Write 3 has address 'h555 and `wr_data[7:0]`='hD0. Write 4 may use any address and stores `wr_data`. Addresses compare over the full width, and `wr_data[15:8]` is ignored during writes 1 to 3. The new word appears on the outputs from the clock edge that samples write 4.
- R3: A write that does not match the expected next unlock step returns the sequencer to idle. It does not change `cfg_word`.
- R4: A write that matches step 1 restarts the sequence from any unlock state, so the next expected write is step 2.
- R5: If `pgm_busy` is high during write 4, the word is discarded and the sequencer returns to idle. `pgm_busy` has no effect during writes 1 to 3.
- R6: `async_rd` equals bit 15 of the stored word: 1 selects asynchronous reads and 0 selects synchronous burst reads.
- R7: `iad_cycles` equals bits 13:10 of the stored word plus 2. For example, code 0000 gives 2 cycles and code 0111 gives 9 cycles.
- R8: `burst_linear` equals bit 7 of the stored word (1 linear, 0 interleaved). `clk_rise` equals bit 6.
- R9: Burst length codes in bits 2:0 decode as follows. Codes 001, 010, 011 and 100 give `burst_bytes` of 8, 16, 32 and 64 with `burst_cont` low. Code 111 and the reserved codes 000, 101 and 110 give `burst_cont` high with `burst_bytes` 0.
- R10: Cycles with `wr_en` low neither advance nor abort the sequence, and they leave `cfg_word` unchanged.
- R11: Bits 5:3 of `cfg_word` always read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe (chip selected and write asserted) |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 16 | Write data |
| pgm_busy | input | 1 | Embedded program/erase in progress |
| cfg_word | output | 16 | Stored configuration word |
| async_rd | output | 1 | 1 = asynchronous reads, 0 = synchronous burst |
| iad_cycles | output | 5 | Initial access latency in clock cycles |
| burst_linear | output | 1 | 1 = linear, 0 = interleaved burst order |
| clk_rise | output | 1 | Output clock edge select |
| burst_bytes | output | 8 | Burst length in bytes, 0 when continuous |
| burst_cont | output | 1 | Continuous burst |

## Verification
The assertions assume that `pgm_busy` and the write inputs are settled at each rising edge. They also assume that a change of `cfg_word` can only follow a cycle in which a write was present. The stimulus changes inputs only on falling edges and holds `wr_en` for exactly one cycle per write. It mixes complete commands, broken and restarted commands, and idle gaps, and raises `pgm_busy` at random, so the busy guard is exercised on every command step.

// File: rtl/bfcfg_pkg.sv
package bfcfg_pkg;
  localparam int CFG_W = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2,
    SEQ_GOT3 = 2'd3
  } seq_t;

  // field positions decoded by the read side
  localparam int B_MODE   = 15;
  localparam int B_DLY_HI = 13;
  localparam int B_DLY_LO = 10;
  localparam int B_ORDER  = 7;
  localparam int B_EDGE   = 6;
  localparam int B_PAD_HI = 5;
  localparam int B_PAD_LO = 3;
  localparam int B_LEN_HI = 2;
endpackage

// File: rtl/bfcfg_seq.sv
module bfcfg_seq
  import bfcfg_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] STEP_A1 = 12'h555,
  parameter logic [11:0] STEP_A2 = 12'h2AA,
  parameter logic [7:0]  STEP_D1 = 8'hAA,
  parameter logic [7:0]  STEP_D2 = 8'h55,
  parameter logic [7:0]  STEP_D3 = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_lo,
  input  logic              pgm_busy,
  output logic              load
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(STEP_A1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(STEP_A2);

  seq_t state, state_nx;
  logic hit1, hit2, hit3;

  assign hit1 = (wr_addr == A1) && (wr_lo == STEP_D1);
  assign hit2 = (wr_addr == A2) && (wr_lo == STEP_D2);
  assign hit3 = (wr_addr == A1) && (wr_lo == STEP_D3);

  always_comb begin
    state_nx = state;
    load     = 1'b0;
    if (wr_en) begin
      if (state == SEQ_GOT3) begin
        load     = !pgm_busy;
        state_nx = SEQ_IDLE;
      end else if (hit1) begin
        state_nx = SEQ_GOT1;
      end else if (state == SEQ_GOT1 && hit2) begin
        state_nx = SEQ_GOT2;
      end else if (state == SEQ_GOT2 && hit3) begin
        state_nx = SEQ_GOT3;
      end else begin
        state_nx = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/bfcfg_reg.sv
module bfcfg_reg
  import bfcfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_WORD = 16'h9CC7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] q
);
  logic [CFG_W-1:0] keep_mask;

  // bits outside the pad field are stored, pad bits are tied low
  for (genvar i = 0; i < CFG_W; i++) begin : g_mask
    assign keep_mask[i] = !(i >= B_PAD_LO && i <= B_PAD_HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= RESET_WORD & keep_mask;
    else if (load) q <= din & keep_mask;
  end
endmodule

// File: rtl/bfcfg_decode.sv
module bfcfg_decode
  import bfcfg_pkg::*;
#(
  parameter int DLY_BASE = 2
) (
  input  logic       mode_bit,
  input  logic [3:0] dly_code,
  input  logic       order_bit,
  input  logic       edge_bit,
  input  logic [2:0] len_code,
  output logic       async_rd,
  output logic [4:0] iad_cycles,
  output logic       burst_linear,
  output logic       clk_rise,
  output logic [7:0] burst_bytes,
  output logic       burst_cont
);
  assign async_rd     = mode_bit;
  assign iad_cycles   = {1'b0, dly_code} + 5'(DLY_BASE);
  assign burst_linear = order_bit;
  assign clk_rise     = edge_bit;

  always_comb begin
    burst_bytes = 8'd0;
    burst_cont  = 1'b1;
    if (len_code >= 3'd1 && len_code <= 3'd4) begin
      burst_bytes = 8'd4 << len_code;
      burst_cont  = 1'b0;
    end
  end
endmodule

// File: rtl/bfcfg_top.sv
module bfcfg_top
  import bfcfg_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter logic [15:0] RESET_WORD = 16'h9CC7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              pgm_busy,
  output logic [15:0]       cfg_word,
  output logic              async_rd,
  output logic [4:0]        iad_cycles,
  output logic              burst_linear,
  output logic              clk_rise,
  output logic [7:0]        burst_bytes,
  output logic              burst_cont
);
  logic load;

  bfcfg_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_lo(wr_data[7:0]), .pgm_busy(pgm_busy), .load(load)
  );

  bfcfg_reg #(.RESET_WORD(RESET_WORD)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .din(wr_data), .q(cfg_word)
  );

  bfcfg_decode u_dec (
    .mode_bit(cfg_word[B_MODE]),
    .dly_code(cfg_word[B_DLY_HI:B_DLY_LO]),
    .order_bit(cfg_word[B_ORDER]),
    .edge_bit(cfg_word[B_EDGE]),
    .len_code(cfg_word[B_LEN_HI:0]),
    .async_rd(async_rd),
    .iad_cycles(iad_cycles),
    .burst_linear(burst_linear),
    .clk_rise(clk_rise),
    .burst_bytes(burst_bytes),
    .burst_cont(burst_cont)
  );
endmodule

// File: rtl/bfcfg_chk.sv
module bfcfg_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic              pgm_busy,
  input logic [15:0]       cfg_word,
  input logic [4:0]        iad_cycles,
  input logic [7:0]        burst_bytes,
  input logic              burst_cont
);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_word));

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pgm_busy) |=> $stable(cfg_word));

  a_r11_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[5:3] == 3'b000);

  a_r7_delay_range: assert property (@(posedge clk) disable iff (!rst_n)
    (iad_cycles >= 5'd2) && (iad_cycles <= 5'd17));

  a_r9_cont_no_len: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cont |-> (burst_bytes == 8'd0));

  a_r9_len_power: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_cont |-> ($countones(burst_bytes) == 1 && burst_bytes >= 8'd8 && burst_bytes <= 8'd64));
endmodule

bind bfcfg_top bfcfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pgm_busy(pgm_busy), .cfg_word(cfg_word),
  .iad_cycles(iad_cycles), .burst_bytes(burst_bytes), .burst_cont(burst_cont)
);

// File: tb/sim_bfcfg_top.sv
`timescale 1ns/1ps
module sim_bfcfg_top;
  localparam int CLK_NS = 10;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pgm_busy = 1'b0;
  logic [15:0] cfg_word;
  logic async_rd, burst_linear, clk_rise, burst_cont;
  logic [4:0] iad_cycles;
  logic [7:0] burst_bytes;

  int checks = 0;
  int failures = 0;
  int mstep = 0;
  logic [15:0] mcfg = 16'h9CC7;

  always #(CLK_NS/2) clk = ~clk;

  bfcfg_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pgm_busy(pgm_busy), .cfg_word(cfg_word),
    .async_rd(async_rd), .iad_cycles(iad_cycles), .burst_linear(burst_linear),
    .clk_rise(clk_rise), .burst_bytes(burst_bytes), .burst_cont(burst_cont)
  );

  function automatic logic [7:0] exp_bytes(input logic [2:0] c);
    case (c)
      3'd1: return 8'd8;
      3'd2: return 8'd16;
      3'd3: return 8'd32;
      3'd4: return 8'd64;
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "cfg_word", cfg_word, mcfg);
    chk({req, "/R6"}, "async_rd", async_rd, mcfg[15]);
    chk({req, "/R7"}, "iad_cycles", iad_cycles, int'(mcfg[13:10]) + 2);
    chk({req, "/R8"}, "burst_linear", burst_linear, mcfg[7]);
    chk({req, "/R8"}, "clk_rise", clk_rise, mcfg[6]);
    chk({req, "/R9"}, "burst_bytes", burst_bytes, exp_bytes(mcfg[2:0]));
    chk({req, "/R9"}, "burst_cont", burst_cont, exp_bytes(mcfg[2:0]) == 8'd0);
  endtask

  // one bus write; inputs change on falling edges, result sampled on the next falling edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d, input logic b);
    wr_en = 1'b1; wr_addr = a; wr_data = d; pgm_busy = b;
    @(negedge clk);
    wr_en = 1'b0; pgm_busy = 1'b0;
    if (mstep == 3) begin
      if (!b) mcfg = d & ~16'h0038;
      mstep = 0;
    end else if (a == 12'h555 && d[7:0] == 8'hAA) mstep = 1;
    else if (mstep == 1 && a == 12'h2AA && d[7:0] == 8'h55) mstep = 2;
    else if (mstep == 2 && a == 12'h555 && d[7:0] == 8'hD0) mstep = 3;
    else mstep = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic full_cmd(input logic [15:0] w, input logic b);
    bus_wr(12'h555, {$urandom_range(255, 0), 8'hAA}, 1'b0);
    bus_wr(12'h2AA, 16'h0055, $urandom_range(1, 0) == 1);
    bus_wr(12'h555, 16'h00D0, 1'b0);
    bus_wr(12'($urandom), w, b);
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 / R11: plain load with pad bits set
    full_cmd(16'h123C, 1'b0);
    check_all("R2");
    chk("R11", "pad", cfg_word[5:3], 0);

    // R3: wrong address at step 3, then a would-be data word
    bus_wr(12'h555, 16'h00AA, 1'b0);
    bus_wr(12'h2AA, 16'h0055, 1'b0);
    bus_wr(12'h123, 16'h00D0, 1'b0);
    bus_wr(12'h000, 16'hFFFF, 1'b0);
    check_all("R3");

    // R4: repeated step 1 restarts
    bus_wr(12'h555, 16'h00AA, 1'b0);
    bus_wr(12'h2AA, 16'h0055, 1'b0);
    bus_wr(12'h555, 16'h00AA, 1'b0);
    bus_wr(12'h2AA, 16'h0055, 1'b0);
    bus_wr(12'h555, 16'h00D0, 1'b0);
    bus_wr(12'h7FF, 16'h4C41, 1'b0);
    check_all("R4");

    // R5: busy on data write discards, and the sequencer is idle afterwards
    full_cmd(16'h0002, 1'b1);
    check_all("R5");
    bus_wr(12'h001, 16'h0003, 1'b0);
    check_all("R5");

    // R10: idle gaps between steps
    bus_wr(12'h555, 16'h00AA, 1'b0); idle(4);
    bus_wr(12'h2AA, 16'h0055, 1'b0); idle(2);
    bus_wr(12'h555, 16'h00D0, 1'b0); idle(5);
    check_all("R10");
    bus_wr(12'h0AB, 16'h80C4, 1'b0);
    check_all("R10");

    // R7 / R9 / R6 / R8: sweep codes
    for (int k = 0; k < 16; k++) begin
      full_cmd({k[0], 1'b0, k[3:0], 2'b00, k[1], k[2], 3'b111, k[2:0]}, 1'b0);
      check_all("R7");
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(9, 0);
      if (sel < 3) begin
        full_cmd(16'($urandom), $urandom_range(5, 0) == 0);
      end else if (sel < 5) begin
        idle($urandom_range(3, 1));
      end else begin
        logic [AW-1:0] a;
        logic [15:0] d;
        case ($urandom_range(2, 0))
          0: a = 12'h555;
          1: a = 12'h2AA;
          default: a = 12'($urandom);
        endcase
        case ($urandom_range(3, 0))
          0: d = {8'($urandom), 8'hAA};
          1: d = {8'($urandom), 8'h55};
          2: d = {8'($urandom), 8'hD0};
          default: d = 16'($urandom);
        endcase
        bus_wr(a, d, $urandom_range(5, 0) == 0);
      end
      check_all("R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule